// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block takes two free-running clocks with no fixed frequency or phase relation and produces one output clock from the source named by a level select input. When the select changes, the handover is done in two halves. The path from the old clock closes on one of its own falling edges. The path from the new clock opens only after the closure has been seen in the new clock's domain, and the output restarts on a rising edge of the new clock. As a result, the output never carries a clipped high or low phase during an ordinary switch.

A normal handover needs the old clock to keep toggling. A separate force input covers the case where that clock has stopped. While force is high, the path of the clock that select does not name is cut at once, without waiting for any edge. The named clock then starts on its own after a short synchronizer delay. An active-high gate input overrides everything else and parks the output at a chosen idle level.

Top module: `clk_switch`

## Requirements
- R1: With `sel_i` = 1 the output follows `clk1_i` and with `sel_i` = 0 it follows `clk2_i`: once a handover has settled, `clk_o` is high during every high phase of the selected clock and low during every low phase.
- R2: After `sel_i` changes, `clk_o` makes its last fall on a falling edge of the previously selected clock and then stays low. This last fall comes no later than three periods of that clock after the select change.
- R3: After that last fall, `clk_o` stays low for at most three periods of the newly selected clock. It then rises at the same instant as a rising edge of the newly selected clock.
- R4: During ordinary switching and start-up, no high or low pulse on `clk_o` is shorter than the shorter half-period of the two inputs. The two clock paths are never open at the same time.
- R5: While `rst_ni` is low, `clk_o` is low. After release, `clk_o` starts on a rising edge of the clock named by `sel_i`, within three periods of that clock.
- R6: A rise on `force_i` cuts the unnamed clock's path asynchronously, so `clk_o` drops in the same instant even if that clock has stopped high. `clk_o` then restarts on the named clock within three of its periods.
- R7: While `force_i` is high, the unnamed clock may run, stop high or stop low, and `clk_o` keeps following the named clock unchanged.
- R8: To change source under force, lower `force_i`, flip `sel_i` and raise `force_i` again. `clk_o` then moves to the newly named clock.
- R9: While `gate_i` is 1, `clk_o` equals `idle_i` at once, whatever the clocks do. With `gate_i` at 0, normal switching resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1_i | input | 1 | Clock source chosen when `sel_i` = 1 |
| clk2_i | input | 1 | Clock source chosen when `sel_i` = 0 |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Level source select |
| force_i | input | 1 | Cuts the unnamed source path at once |
| gate_i | input | 1 | Output override enable |
| idle_i | input | 1 | Level driven on `clk_o` while gated |
| clk_o | output | 1 | Switched output clock |

## Verification
In steady state, the expected output is the selected clock itself. The bench samples `clk_o` 1 ns after each edge of that clock, so one register stage of margin is never needed. Handover results are deadlines in real time rather than fixed cycle counts. The last fall must come within three old-clock periods of the stimulus, and the restart must land on a new-clock rising edge within three new-clock periods after that fall. The bench polls in 1 ns steps until the restart is seen, then compares the measured intervals against those bounds. The force cut and the gate override are combinational, so their effect is checked 1 ns after the input moves.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    SRC_CLK2 = 1'b0,
    SRC_CLK1 = 1'b1
  } src_e;
endpackage

// File: rtl/clk_switch_sync.sv
module clk_switch_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)     chain_q <= '0;
    else if (clr_i)  chain_q <= '0;
    else             chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_switch_leg.sv
module clk_switch_leg
  import clk_switch_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES_DEF,
  parameter src_e        PICK   = SRC_CLK1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic force_i,
  input  logic peer_en_i,
  output logic en_o
);
  logic named, kill, want, peer_seen;

  assign named = (src_e'(sel_i) == PICK);
  // force cuts the unnamed path without waiting for its clock
  assign kill  = force_i & ~named;

  clk_switch_sync #(.STAGES(STAGES)) u_want (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (kill),
    .d_i    (named),
    .q_o    (want)
  );

  clk_switch_sync #(.STAGES(STAGES)) u_peer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .d_i    (peer_en_i),
    .q_o    (peer_seen)
  );

  // falling-edge update keeps the AND gate change inside the low phase
  always_ff @(negedge clk_i or negedge rst_ni or posedge kill) begin
    if (!rst_ni)    en_o <= 1'b0;
    else if (kill)  en_o <= 1'b0;
    else            en_o <= want & ~peer_seen;
  end
endmodule

// File: rtl/clk_switch.sv
module clk_switch
  import clk_switch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk1_i,
  input  logic clk2_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic force_i,
  input  logic gate_i,
  input  logic idle_i,
  output logic clk_o
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] en_v;
  logic            mux_clk;

  assign src_clk = {clk1_i, clk2_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    clk_switch_leg #(
      .STAGES (SYNC_STAGES),
      .PICK   ((g == 1) ? SRC_CLK1 : SRC_CLK2)
    ) u_leg (
      .clk_i     (src_clk[g]),
      .rst_ni    (rst_ni),
      .sel_i     (sel_i),
      .force_i   (force_i),
      .peer_en_i (en_v[NSRC-1-g]),
      .en_o      (en_v[g])
    );
  end

  assign mux_clk = |(src_clk & en_v);
  assign clk_o   = gate_i ? idle_i : mux_clk;
endmodule

// File: rtl/clk_switch_chk.sv
module clk_switch_chk (
  input logic       clk1_i,
  input logic       clk2_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       force_i,
  input logic       gate_i,
  input logic       idle_i,
  input logic       clk_o,
  input logic [1:0] en_i
);
  AST_ONE_PATH_C1: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    $countones(en_i) <= 1); // R4
  AST_ONE_PATH_C2: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    $countones(en_i) <= 1); // R4
  AST_FORCE_CUTS_C2: assert property (@(posedge clk2_i) disable iff (!rst_ni)
    (force_i && sel_i) |-> !en_i[0]); // R6
  AST_FORCE_CUTS_C1: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (force_i && !sel_i) |-> !en_i[1]); // R7
  AST_GATE_LEVEL: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    gate_i |-> (clk_o == idle_i)); // R9
endmodule

bind clk_switch clk_switch_chk u_chk (
  .clk1_i  (clk1_i),
  .clk2_i  (clk2_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .force_i (force_i),
  .gate_i  (gate_i),
  .idle_i  (idle_i),
  .clk_o   (clk_o),
  .en_i    (en_v)
);

// File: tb/tb_clk_switch.sv
`timescale 1ns/1ps
module tb_clk_switch;
  localparam real T1 = 20.0;    // 50 MHz
  localparam real T2 = 29.5;
  localparam real MIN_HALF = 10.0;

  logic clk1 = 1'b0, clk2 = 1'b0;
  logic rst_n = 1'b0, sel = 1'b1, frc = 1'b0, gate = 1'b0, idle = 1'b0;
  logic clk_o;
  bit   run1 = 1'b1, run2 = 1'b1;
  real  rise1_t = -1.0, rise2_t = -1.0;

  int   vectors = 0, miscompares = 0;
  bit   finished = 1'b0;

  // handover measurement state
  real  t0, t_fall, t_rise;
  bit   armed = 1'b0, got_new = 1'b0;
  int   new_src_m = 1;

  // pulse monitor state
  bit   exempt = 1'b1, have_prev = 1'b0;
  real  last_edge = 0.0;

  clk_switch dut (
    .clk1_i  (clk1),
    .clk2_i  (clk2),
    .rst_ni  (rst_n),
    .sel_i   (sel),
    .force_i (frc),
    .gate_i  (gate),
    .idle_i  (idle),
    .clk_o   (clk_o)
  );

  initial forever begin
    #(T1/2);
    if (run1) begin
      if (!clk1) rise1_t = $realtime;
      clk1 = ~clk1;
    end
  end

  initial begin
    #3.3;
    forever begin
      if (run2) begin
        if (!clk2) rise2_t = $realtime;
        clk2 = ~clk2;
      end
      #(T2/2);
    end
  end

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: clk_o got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_r(input bit ok, input string req, input real act, input real exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: interval got %0.3f ns expected <= %0.3f ns at %0t", req, act, exp, $time);
    end
  endtask

  // R4: every clean pulse is at least the shorter half-period
  always @(clk_o) begin
    if (!exempt && have_prev && !finished) begin
      vectors++;
      if ($realtime - last_edge < MIN_HALF - 0.01) begin
        miscompares++;
        $display("FAIL R4: pulse width got %0.3f ns expected >= %0.3f ns", $realtime - last_edge, MIN_HALF);
      end
    end
    have_prev = !exempt;
    last_edge = $realtime;
  end

  always @(negedge clk_o) if (armed && !got_new) t_fall = $realtime;

  always @(posedge clk_o) begin
    if (armed && !got_new) begin
      if ((new_src_m == 1 && rise1_t == $realtime) || (new_src_m == 2 && rise2_t == $realtime)) begin
        got_new = 1'b1;
        t_rise  = $realtime;
      end
    end
  end

  task automatic steady(input int src, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      if (src == 1) @(posedge clk1); else @(posedge clk2);
      #1 chk(clk_o === 1'b1, req, clk_o, 1'b1);
      if (src == 1) @(negedge clk1); else @(negedge clk2);
      #1 chk(clk_o === 1'b0, req, clk_o, 1'b0);
    end
  endtask

  // act: 0 select change, 1 reset release, 2 force rise
  task automatic handover(input int act, input logic new_sel, input real drop_lim,
                          input real t_new, input string rq_drop, input string rq_rise);
    new_src_m = new_sel ? 1 : 2;
    got_new   = 1'b0;
    t0        = $realtime;
    t_fall    = t0;
    armed     = 1'b1;
    case (act)
      0: sel = new_sel;
      1: begin rst_n = 1'b1; exempt = 1'b0; end
      default: frc = 1'b1;
    endcase
    for (int i = 0; i < int'(3.0*T1 + 3.0*T2) + 6 && !got_new; i++) #1;
    armed = 1'b0;
    chk_r(t_fall - t0 <= drop_lim + 0.01, rq_drop, t_fall - t0, drop_lim);
    chk_r(got_new && (t_rise - t_fall <= 3.0*t_new + 0.01), rq_rise,
          got_new ? t_rise - t_fall : -1.0, 3.0*t_new);
  endtask

  initial begin
    // R5: low in reset
    #12.4 chk(clk_o === 1'b0, "R5", clk_o, 1'b0);
    #21.7 chk(clk_o === 1'b0, "R5", clk_o, 1'b0);
    handover(1, 1'b1, 0.0, T1, "R5", "R5");
    steady(1, 5, "R1");

    // R2/R3 at several phase offsets
    for (int k = 0; k < 4; k++) begin
      logic ns;
      ns = ~sel;
      #(k*3.7 + 1.3);
      handover(0, ns, 3.0*(sel ? T1 : T2), ns ? T1 : T2, "R2", "R3");
      steady(ns ? 1 : 2, 4, "R1");
    end

    // R9: gate override
    exempt = 1'b1;
    #3.1 gate = 1'b1; idle = 1'b1;
    #1 chk(clk_o === 1'b1, "R9", clk_o, 1'b1);
    repeat (6) begin #7.3 chk(clk_o === 1'b1, "R9", clk_o, 1'b1); end
    idle = 1'b0;
    #1 chk(clk_o === 1'b0, "R9", clk_o, 1'b0);
    repeat (6) begin #7.3 chk(clk_o === 1'b0, "R9", clk_o, 1'b0); end
    @(negedge clk1); #1 gate = 1'b0;
    #2 exempt = 1'b0;
    steady(1, 3, "R9");

    // R6: old clock dies high, force completes the switch
    handover(0, 1'b0, 3.0*T1, T2, "R2", "R3");
    steady(2, 3, "R1");
    @(posedge clk2); #2 run2 = 1'b0;
    #1 chk(clk_o === 1'b1, "R6", clk_o, 1'b1);
    sel = 1'b1;
    #100 chk(clk_o === 1'b1, "R6", clk_o, 1'b1);
    handover(2, 1'b1, 0.0, T1, "R6", "R6");
    steady(1, 4, "R6");

    // R7: unnamed clock restarts, stops low, restarts under force
    run2 = 1'b1;
    steady(1, 10, "R7");
    @(negedge clk2); #2 run2 = 1'b0;
    steady(1, 5, "R7");
    run2 = 1'b1;
    steady(1, 3, "R7");

    // R8: lower force, flip select, raise force
    frc = 1'b0;
    #7 steady(1, 3, "R8");
    exempt = 1'b1;
    sel = 1'b0;
    #5 handover(2, 1'b0, 0.0, T2, "R8", "R8");
    exempt = 1'b0;
    steady(2, 5, "R8");
    frc = 1'b0;
    steady(2, 3, "R1");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule